// File: doc/BRIEF.md
# Serial Wire Debug Transfer Engine

This block is the host side of a two-wire serial debug link. A single start strobe launches one register access to the target. The block builds and sends the 8-bit request header. It then releases the data line for a configurable turnaround and reads the target's 3-bit acknowledge. After that it completes the path the acknowledge selects: a 33-bit read with a parity check, a 33-bit write with generated parity, a wait/fault recovery, or a back-off when the acknowledge is not recognised. A completed access ends with optional trailing idle clocks, and the block then pulses `done` for one cycle.

The serial clock is derived from the system clock, and its rate is set by a delay input. The data line has separate output, output-enable and input signals, so a pad or tristate buffer outside the block combines them. The request fields, write word, turnaround length, idle count, data-phase option and delay are all captured when the start strobe is accepted. They may change freely while the access runs.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is sent LSB first while `swdioOe` is 1, as the bits 1, req[0], req[1], req[2], req[3], even parity of req, 0, 1. The request fields are req[0]=AP/DP select, req[1]=read (1) / write (0), req[3:2]=register address bits A[3:2].
- R2: After the header, the line is released for T = trnSel+1 clocks (1 to 4). Then 3 acknowledge bits are sampled LSB first. Bits seen during the turnaround never reach the status. The codes are OK=3'b001, WAIT=3'b010 and FAULT=3'b100, and an OK access reports 3'b001 on `ackStatus`.
- R3: For a read with an OK acknowledge, the block samples 32 data bits LSB first and then 1 parity bit, all with the line released. It follows them with T released clocks, and `rdata` then holds the sampled word.
- R4: If the sampled read parity does not equal the XOR of the 32 data bits, `ackStatus` is 3'b111 and `parityErr` is 1. `rdata` still shows the sampled word.
- R5: For a write with an OK acknowledge, the block gives T released clocks. It then drives the 32-bit write word LSB first, followed by the word's even parity bit.
- R6: After an OK access, the block drives the line low for `idleCnt` clocks (none when 0). `done` is then high for exactly one cycle.
- R7: On WAIT or FAULT with `dataPhase`=1, a read samples 33 ignored bits and then gives T released clocks. A write gives T released clocks and then drives 33 zero bits. `ackStatus` carries the raw acknowledge.
- R8: On WAIT or FAULT with `dataPhase`=0, the access ends after only T released clocks.
- R9: Any other acknowledge value keeps the line released for T+33 further clocks. `ackStatus` then reports the raw value.
- R10: One serial clock period lasts 2*(clkDelay+1) system clocks. `swclk` is low and `swdioOe` is 0 whenever no access is running, including after reset.
- R11: `swdioOut` and `swdioOe` change only while `swclk` is low, that is, on the falling half. The input is sampled when `swclk` rises.
- R12: A start while `busy` is 1 is ignored and has no later effect. A start in the cycle in which `done` is high begins a new access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one access (accepted while idle) |
| req | input | 4 | Request fields: [0] AP/DP, [1] read, [3:2] address |
| wdata | input | 32 | Word to write |
| trnSel | input | 2 | Turnaround length minus one |
| idleCnt | input | IDLE_W | Trailing low clocks after an OK access |
| dataPhase | input | 1 | Run the dummy data phase on WAIT/FAULT |
| clkDelay | input | DLY_W | Serial clock half-period minus one, in system clocks |
| swclk | output | 1 | Serial clock |
| swdioOut | output | 1 | Data line output value |
| swdioOe | output | 1 | Data line output enable |
| swdioIn | input | 1 | Data line input value |
| rdata | output | 32 | Word captured by the last OK read |
| ackStatus | output | 3 | Acknowledge or error status of the last access |
| parityErr | output | 1 | Read parity mismatch on the last access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one access and the acceptance of the next start can fall in the same cycle. The bench waits for `done` and raises `start` in that same cycle with a new request. It then judges that `busy` is set one cycle later and that the second access carries its own header and bit count. A start raised mid-access, with the request inputs changed at the same moment, checks the opposite case: the running header and total clock count stay those of the first request, and no access follows it.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [2:0] STAT_PARITY = 3'b111;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {DRV_NONE, DRV_HDR, DRV_WR} drvSel_e;

  typedef struct packed {
    logic    load;
    logic    shiftHdr;
    logic    shiftWr;
    logic    sampleAck;
    logic    sampleRd;
    logic    finish;
    drvSel_e drv;
  } dpCtl_t;
endpackage

// File: rtl/swd_dp.sv
module swd_dp
  import swd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [3:0]        req,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sdi,
  output logic              sdo,
  output logic [2:0]        ackOut,
  output logic              rnw,
  output logic [WORD_W-1:0] rdata,
  output logic [2:0]        status,
  output logic              parErr
);
  logic [7:0]      hdrSh;
  logic [WORD_W:0] wrSh;
  logic [WORD_W:0] rdSh;
  logic [2:0]      ackSh;
  logic            rnwQ;
  logic            okRead;
  logic            badPar;

  assign okRead = rnwQ && (ackSh == ACK_OK);
  assign badPar = okRead && ((^rdSh[WORD_W-1:0]) != rdSh[WORD_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrSh  <= '0;
      wrSh   <= '0;
      rdSh   <= '0;
      ackSh  <= '0;
      rnwQ   <= 1'b0;
      rdata  <= '0;
      status <= '0;
      parErr <= 1'b0;
    end else begin
      if (ctl.load) begin
        hdrSh <= {1'b1, 1'b0, ^req, req, 1'b1};
        wrSh  <= {^wdata, wdata};
        rnwQ  <= req[1];
      end
      if (ctl.shiftHdr)  hdrSh <= {1'b0, hdrSh[7:1]};
      if (ctl.shiftWr)   wrSh  <= {1'b0, wrSh[WORD_W:1]};
      if (ctl.sampleAck) ackSh <= {sdi, ackSh[2:1]};
      if (ctl.sampleRd)  rdSh  <= {sdi, rdSh[WORD_W:1]};
      if (ctl.finish) begin
        status <= badPar ? STAT_PARITY : ackSh;
        parErr <= badPar;
        if (okRead) rdata <= rdSh[WORD_W-1:0];
      end
    end
  end

  always_comb begin
    case (ctl.drv)
      DRV_HDR: sdo = hdrSh[0];
      DRV_WR:  sdo = wrSh[0];
      default: sdo = 1'b0;
    endcase
  end

  assign ackOut = ackSh;
  assign rnw    = rnwQ;

  // R11: at most one shift/sample/load action per cycle
  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.shiftHdr, ctl.shiftWr, ctl.sampleAck, ctl.sampleRd}));

  // R4: the parity flag only ever accompanies the parity status code
  assert_parity_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> status == STAT_PARITY);
endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int IDLE_W = 8,
  parameter int TRN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TRN_W-1:0]  trnSel,
  input  logic [IDLE_W-1:0] idleCnt,
  input  logic              dataPhase,
  input  logic [DLY_W-1:0]  clkDelay,
  input  logic [2:0]        ackIn,
  input  logic              rnw,
  output logic              swclk,
  output logic              swdioOe,
  output logic              busy,
  output logic              done,
  output dpCtl_t            ctl
);
  localparam int CNT_W = (IDLE_W > 6) ? IDLE_W + 1 : 7;
  localparam logic [CNT_W-1:0] HDR_LEN = CNT_W'(8);
  localparam logic [CNT_W-1:0] ACK_LEN = CNT_W'(3);
  localparam logic [CNT_W-1:0] DAT_LEN = CNT_W'(WORD_W + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_TRN1, S_ACK, S_RDAT, S_TRN2,
    S_WDAT, S_DUMR, S_DUMW, S_BACK, S_TAIL
  } state_e;

  state_e            state, nxtState, tailState;
  logic [CNT_W-1:0]  bitsLeft, nxtLen, tailLen, trnQ;
  logic [IDLE_W-1:0] idleQ;
  logic [DLY_W-1:0]  dlyQ, tickCnt;
  logic              dphQ, swclkQ, doneQ;
  logic              tick, riseEdge, fallEdge, lastBit, ackOk, ackWf;

  assign busy     = (state != S_IDLE);
  assign tick     = busy && (tickCnt == dlyQ);
  assign riseEdge = tick && !swclkQ;
  assign fallEdge = tick && swclkQ;
  assign lastBit  = (bitsLeft == CNT_W'(1));
  assign ackOk    = (ackIn == ACK_OK);
  assign ackWf    = (ackIn == ACK_WAIT) || (ackIn == ACK_FAULT);

  always_comb begin
    if (idleQ == '0) begin
      tailState = S_IDLE;
      tailLen   = '0;
    end else begin
      tailState = S_TAIL;
      tailLen   = CNT_W'(idleQ);
    end
  end

  always_comb begin
    nxtState = S_IDLE;
    nxtLen   = '0;
    case (state)
      S_HDR:  begin nxtState = S_TRN1; nxtLen = trnQ; end
      S_TRN1: begin nxtState = S_ACK;  nxtLen = ACK_LEN; end
      S_ACK: begin
        if (ackOk) begin
          nxtState = rnw ? S_RDAT : S_TRN2;
          nxtLen   = rnw ? DAT_LEN : trnQ;
        end else if (ackWf && rnw && dphQ) begin
          nxtState = S_DUMR; nxtLen = DAT_LEN;
        end else if (ackWf) begin
          nxtState = S_TRN2; nxtLen = trnQ;
        end else begin
          nxtState = S_BACK; nxtLen = trnQ + DAT_LEN;
        end
      end
      S_RDAT, S_DUMR: begin nxtState = S_TRN2; nxtLen = trnQ; end
      S_TRN2: begin
        if (ackOk && rnw) begin
          nxtState = tailState; nxtLen = tailLen;
        end else if (ackOk) begin
          nxtState = S_WDAT; nxtLen = DAT_LEN;
        end else if (ackWf && !rnw && dphQ) begin
          nxtState = S_DUMW; nxtLen = DAT_LEN;
        end
      end
      S_WDAT: begin nxtState = tailState; nxtLen = tailLen; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitsLeft <= '0;
      trnQ     <= '0;
      idleQ    <= '0;
      dlyQ     <= '0;
      tickCnt  <= '0;
      dphQ     <= 1'b0;
      swclkQ   <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.load) begin
        state    <= S_HDR;
        bitsLeft <= HDR_LEN;
        trnQ     <= CNT_W'(trnSel) + CNT_W'(1);
        idleQ    <= idleCnt;
        dlyQ     <= clkDelay;
        dphQ     <= dataPhase;
        tickCnt  <= '0;
        swclkQ   <= 1'b0;
      end else if (busy) begin
        tickCnt <= tick ? '0 : tickCnt + DLY_W'(1);
        if (riseEdge) swclkQ <= 1'b1;
        if (fallEdge) begin
          swclkQ <= 1'b0;
          if (!lastBit) begin
            bitsLeft <= bitsLeft - CNT_W'(1);
          end else begin
            state    <= nxtState;
            bitsLeft <= nxtLen;
            doneQ    <= (nxtState == S_IDLE);
          end
        end
      end
    end
  end

  always_comb begin
    ctl.load      = start && !busy;
    ctl.shiftHdr  = fallEdge && !lastBit && (state == S_HDR);
    ctl.shiftWr   = fallEdge && !lastBit && (state == S_WDAT);
    ctl.sampleAck = riseEdge && (state == S_ACK);
    ctl.sampleRd  = riseEdge && (state == S_RDAT);
    ctl.finish    = fallEdge && lastBit && (nxtState == S_IDLE);
    case (state)
      S_HDR:   ctl.drv = DRV_HDR;
      S_WDAT:  ctl.drv = DRV_WR;
      default: ctl.drv = DRV_NONE;
    endcase
  end

  assign swdioOe = (state == S_HDR) || (state == S_WDAT) ||
                   (state == S_DUMW) || (state == S_TAIL);
  assign swclk   = swclkQ;
  assign done    = doneQ;

  // R10: no clock and no drive when no access runs
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !swclkQ && !swdioOe);

  // R11: the output enable only moves during the low half of the clock
  assert_oe_low_half_R11: assert property (@(posedge clk) disable iff (!rstN)
    $changed(swdioOe) |-> !swclkQ);

  // R12: a start during an access leaves the captured settings alone
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> $stable(dlyQ) && $stable(trnQ) && $stable(idleQ));

  // R6: completion is a single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        req,
  input  logic [31:0]       wdata,
  input  logic [1:0]        trnSel,
  input  logic [IDLE_W-1:0] idleCnt,
  input  logic              dataPhase,
  input  logic [DLY_W-1:0]  clkDelay,
  output logic              swclk,
  output logic              swdioOut,
  output logic              swdioOe,
  input  logic              swdioIn,
  output logic [31:0]       rdata,
  output logic [2:0]        ackStatus,
  output logic              parityErr,
  output logic              busy,
  output logic              done
);
  dpCtl_t     ctl;
  logic [2:0] ackVal;
  logic       rnw;

  swd_ctrl #(.DLY_W(DLY_W), .IDLE_W(IDLE_W), .TRN_W(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .trnSel(trnSel),
    .idleCnt(idleCnt), .dataPhase(dataPhase), .clkDelay(clkDelay),
    .ackIn(ackVal), .rnw(rnw), .swclk(swclk), .swdioOe(swdioOe),
    .busy(busy), .done(done), .ctl(ctl)
  );

  swd_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .req(req), .wdata(wdata),
    .sdi(swdioIn), .sdo(swdioOut), .ackOut(ackVal), .rnw(rnw),
    .rdata(rdata), .status(ackStatus), .parErr(parityErr)
  );

  // R11: a driven data value only changes during the low half of the clock
  assert_data_low_half_R11: assert property (@(posedge clk) disable iff (!rstN)
    swdioOe && $past(swdioOe) && (swdioOut != $past(swdioOut)) |-> !swclk);
endmodule

// File: tb/sim_swd_xfer_engine.sv
module sim_swd_xfer_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] req = '0;
  logic [31:0] wdata = '0;
  logic [1:0] trnSel = '0;
  logic [7:0] idleCnt = '0;
  logic dataPhase = 1'b0;
  logic [7:0] clkDelay = '0;
  logic swdioIn = 1'b1;
  logic swclk, swdioOut, swdioOe, parityErr, busy, done;
  logic [31:0] rdata;
  logic [2:0] ackStatus;

  always #2 clk = ~clk;

  swd_xfer_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .req(req), .wdata(wdata),
    .trnSel(trnSel), .idleCnt(idleCnt), .dataPhase(dataPhase),
    .clkDelay(clkDelay), .swclk(swclk), .swdioOut(swdioOut),
    .swdioOe(swdioOe), .swdioIn(swdioIn), .rdata(rdata),
    .ackStatus(ackStatus), .parityErr(parityErr), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // fields: req[80:77] wdata[76:45] trnSel[44:43] idle[42:39] dph[38]
  //         dly[37:36] ack[35:33] rdResp[32:1] parityFlip[0]
  localparam logic [80:0] VEC [0:7] = '{
    {4'b0110, 32'h0,         2'd0, 4'd2, 1'b0, 2'd0, 3'b001, 32'hA5A5_1234, 1'b0},
    {4'b1001, 32'hDEAD_BEEF, 2'd1, 4'd0, 1'b0, 2'd1, 3'b001, 32'h0,         1'b0},
    {4'b0011, 32'h0,         2'd3, 4'd1, 1'b0, 2'd0, 3'b001, 32'h8000_0001, 1'b1},
    {4'b0010, 32'h0,         2'd0, 4'd3, 1'b1, 2'd2, 3'b010, 32'hFFFF_0000, 1'b0},
    {4'b1100, 32'h1234_5678, 2'd2, 4'd3, 1'b1, 2'd0, 3'b100, 32'h0,         1'b0},
    {4'b0110, 32'h0,         2'd1, 4'd3, 1'b0, 2'd3, 3'b010, 32'h0,         1'b0},
    {4'b0100, 32'h0F0F_0F0F, 2'd0, 4'd2, 1'b1, 2'd0, 3'b111, 32'h0,         1'b0},
    {4'b1010, 32'h0,         2'd2, 4'd2, 1'b0, 2'd1, 3'b000, 32'h0,         1'b0}
  };

  logic drvOe  [0:255];
  logic drvVal [0:255];
  int   riseAt [0:255];
  int   rc;
  int   r11Bad;
  bit   busyAfter;
  int   curT;
  logic [2:0]  curAck;
  logic [31:0] curRd;
  logic        curFlip;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic respBit(input int k);
    if (k >= 8 + curT && k <= 10 + curT) return curAck[k - 8 - curT];
    if (k >= 11 + curT && k <= 42 + curT) return curRd[k - 11 - curT];
    if (k == 43 + curT) return (^curRd) ^ curFlip;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end got %0d expected <150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic doXfer(input logic [80:0] v, input bit probe, input bit chain);
    int cyc;
    logic prevSw;
    logic [1:0] prevPair, pair;
    if (!chain) @(negedge clk);
    req = v[80:77]; wdata = v[76:45]; trnSel = v[44:43];
    idleCnt = {4'b0, v[42:39]}; dataPhase = v[38]; clkDelay = {6'b0, v[37:36]};
    curT = int'(v[44:43]) + 1; curAck = v[35:33]; curRd = v[32:1]; curFlip = v[0];
    rc = 0; r11Bad = 0; swdioIn = respBit(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyAfter = busy;
    cyc = 0; prevSw = 1'b0; prevPair = 2'b00;
    while (!done && cyc < 5000) begin
      cyc++;
      pair = {swdioOe, swdioOe & swdioOut};
      if (pair != prevPair && swclk) r11Bad++;
      prevPair = pair;
      if (swclk && !prevSw && rc < 256) begin
        drvOe[rc] = swdioOe; drvVal[rc] = swdioOut; riseAt[rc] = cyc;
        rc++;
        swdioIn = respBit(rc);
      end
      prevSw = swclk;
      if (probe && cyc == 20) begin
        req = ~req; idleCnt = 8'd9; trnSel = 2'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(cyc < 5000, "R6", "done seen (cycles)", cyc, 5000);
  endtask

  task automatic checkVec(input logic [80:0] v, input bit probe, input bit chain);
    logic [3:0] rq; logic [31:0] wd; logic [2:0] ak; logic [31:0] rd;
    logic fl, dph, rdOp, ok, wf;
    int t, il, dl, expLen, expOe, oeCnt, hiCnt, base;
    logic [7:0] hdrAct, hdrOe, hdrExp;
    logic [32:0] wrAct;
    string tag;
    rq = v[80:77]; wd = v[76:45]; t = int'(v[44:43]) + 1; il = int'(v[42:39]);
    dph = v[38]; dl = int'(v[37:36]); ak = v[35:33]; rd = v[32:1]; fl = v[0];
    rdOp = rq[1]; ok = (ak == 3'b001); wf = (ak == 3'b010) || (ak == 3'b100);
    doXfer(v, probe, chain);

    hdrExp = {1'b1, 1'b0, ^rq, rq, 1'b1};
    for (int k = 0; k < 8; k++) begin
      hdrAct[k] = drvVal[k]; hdrOe[k] = drvOe[k];
    end
    chk(hdrAct == hdrExp && hdrOe == 8'hFF, "R1", "header bits", hdrAct, hdrExp);

    oeCnt = 0;
    for (int k = 8; k <= 10 + t; k++) if (drvOe[k]) oeCnt++;
    chk(oeCnt == 0, "R2", "driven bits in turnaround/ack", oeCnt, 0);

    if (ok) begin
      expLen = 8 + t + 3 + 33 + t + il; expOe = rdOp ? il : 33 + il;
      tag = rdOp ? "R3" : "R5";
    end else if (wf) begin
      expLen = 8 + t + 3 + t + (dph ? 33 : 0);
      expOe = (dph && !rdOp) ? 33 : 0; tag = dph ? "R7" : "R8";
    end else begin
      expLen = 8 + t + 3 + t + 33; expOe = 0; tag = "R9";
    end
    chk(rc == expLen, tag, "serial clock count", rc, expLen);

    oeCnt = 0; hiCnt = 0;
    for (int k = 8; k < rc; k++) if (drvOe[k]) begin oeCnt++; if (drvVal[k]) hiCnt++; end
    chk(oeCnt == expOe, tag, "driven bits after header", oeCnt, expOe);
    if (!(ok && !rdOp)) chk(hiCnt == 0, tag, "driven ones after header", hiCnt, 0);

    if (ok && rdOp && fl) chk(ackStatus == 3'b111 && parityErr, "R4", "parity status",
                              {parityErr, ackStatus}, 4'b1111);
    else chk(ackStatus == ak && !parityErr, tag, "status", {parityErr, ackStatus}, {1'b0, ak});

    if (ok && rdOp) chk(rdata == rd, fl ? "R4" : "R3", "read word", rdata, rd);
    if (ok && !rdOp) begin
      base = 11 + 2 * t;
      for (int k = 0; k < 33; k++) wrAct[k] = drvVal[base + k];
      chk(wrAct == {^wd, wd}, "R5", "write word and parity", wrAct, {^wd, wd});
    end
    if (ok) begin
      oeCnt = 0;
      for (int k = rc - il; k < rc; k++) if (drvOe[k] && !drvVal[k]) oeCnt++;
      chk(oeCnt == il, "R6", "trailing low clocks", oeCnt, il);
    end
    chk(riseAt[1] - riseAt[0] == 2 * (dl + 1), "R10", "serial clock period",
        riseAt[1] - riseAt[0], 2 * (dl + 1));
    chk(r11Bad == 0, "R11", "line changes while clock high", r11Bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!swclk && !swdioOe && !busy && !done, "R10", "reset outputs",
        {swclk, swdioOe, busy, done}, 4'b0);

    for (int i = 0; i < 8; i++) checkVec(VEC[i], 1'b0, 1'b0);

    // R12: start mid-access with changed inputs is ignored
    checkVec(VEC[0], 1'b1, 1'b0);
    begin
      int busySeen;
      busySeen = 0;
      repeat (10) begin @(negedge clk); if (busy) busySeen++; end
      chk(busySeen == 0, "R12", "access after ignored start", busySeen, 0);
    end

    // R12: start in the cycle of done launches the next access
    checkVec(VEC[2], 1'b0, 1'b0);
    checkVec(VEC[1], 1'b0, 1'b1);
    chk(busyAfter, "R12", "busy after start on done cycle", busyAfter, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule